// File: doc/BRIEF.md
# Real-Time Clock Interrupt Unit

This block is the interrupt section of a PC-style real-time clock. It gathers three event sources and turns them into one active-high interrupt line. The first source is a periodic tick divided down from a 32.768 kHz reference enable. The second is an alarm that compares packed-BCD time fields against the current time. The third is an update event that fires once per second. The time-of-day counters are not part of the block: it sees them as a per-second tick input and as current BCD time inputs that are already up to date when the tick arrives.

Software reaches the block through a byte-wide register port with an address, a write strobe and a read strobe. Each source has an enable bit and a flag bit. Flags record events whether or not the source is enabled, and only enabled flags reach the interrupt line. A read of the flags register returns the pending flags and clears them. A time-set strobe tells the block that the seconds counter was just written. The sub-second prescaler then restarts at its midpoint, so the new second starts half a second later.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset the rate code reads 6 (1024 Hz), the control register reads 0x00, the flags register reads 0x00 and `irq` is low.
- R2: The rate register (address 0, bits 3:0) holds code n. Codes 1 to 15 give one periodic event every 2^(n-1) reference ticks, which is 2^(16-n) Hz from 32.768 kHz. Code 0 produces no periodic events.
- R3: On each `sec_tick` the alarm compares the second (address 3), minute (4), hour (5), day (6) and month (7) alarm bytes with the current time. It sets the alarm flag when every field either equals its time input or has bits 7:6 both set, which makes that field a wildcard.
- R4: Every `sec_tick` sets the update flag.
- R5: Flags latch on their event even when the matching enable is clear. Bit positions are the same in control (address 1) and flags (address 2): bit 2 periodic, bit 1 alarm, bit 0 update.
- R6: `irq` and flags bit 7 (summary) are high exactly when some flag is set together with its enable bit.
- R7: A read strobe to address 2 returns the flags and the summary in `reg_rdata` on the next cycle and clears all flags. `irq` goes low in that same cycle, and a second read returns 0x00.
- R8: An event in the same cycle as a flags read is not lost. The read returns the flags from before the event, and the event's flag stays pending.
- R9: The day alarm reads back with bits 7:6 forced to zero. All other registers read back as written.
- R10: A `time_wr` strobe loads the prescaler with its midpoint and suppresses the event in that cycle. For code n the next periodic event then comes exactly 2^(n-1) reference ticks after the strobe.
- R11: Writes to address 2 do not change the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| sec_tick | input | 1 | One-cycle pulse when the seconds counter has advanced |
| time_wr | input | 1 | Pulse: the seconds counter was written, restart the prescaler at midpoint |
| cur_sec | input | 8 | Current seconds, packed BCD |
| cur_min | input | 8 | Current minutes, packed BCD |
| cur_hour | input | 8 | Current hours, packed BCD, 24-hour form |
| cur_day | input | 8 | Current day of month, packed BCD |
| cur_mon | input | 8 | Current month, packed BCD |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered, valid the cycle after `reg_rd` |
| irq | output | 1 | Active-high interrupt request, registered |

## Verification
Two functions can land on the same clock edge: an event that sets a flag, and the flags read that clears them. The bench raises `sec_tick` in the very cycle in which it issues the flags read. It then expects the read to return the flags from before the event, expects `irq` to stay high, and expects a second read to show the update flag. A second collision is the time-set strobe landing on a running prescaler. The bench lines the strobe up right after a read and at a known phase offset, then times the next `irq` to the exact cycle.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DATA_W = 8;
  localparam int REG_AW = 3;
  localparam int NSRC   = 3;

  localparam logic [REG_AW-1:0] A_RATE  = 3'd0;
  localparam logic [REG_AW-1:0] A_CTRL  = 3'd1;
  localparam logic [REG_AW-1:0] A_FLAG  = 3'd2;
  localparam logic [REG_AW-1:0] A_ASEC  = 3'd3;
  localparam logic [REG_AW-1:0] A_AMIN  = 3'd4;
  localparam logic [REG_AW-1:0] A_AHOUR = 3'd5;
  localparam logic [REG_AW-1:0] A_ADAY  = 3'd6;
  localparam logic [REG_AW-1:0] A_AMON  = 3'd7;

  // shared bit positions of enables (control) and flags
  localparam int B_UPD = 0;
  localparam int B_ALM = 1;
  localparam int B_PER = 2;
  localparam int B_SUM = 7;

  // a BCD alarm field with both top bits set accepts any value
  function automatic logic field_hit(input logic [DATA_W-1:0] al,
                                     input logic [DATA_W-1:0] cur);
    return (al[DATA_W-1:DATA_W-2] == 2'b11) || (al == cur);
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W  = 15,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              restart,
  input  logic [CODE_W-1:0] rate_code,
  output logic              per_evt
);
  localparam logic [DIV_W-1:0] MID = DIV_W'(1) << (DIV_W - 1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] mask;

  // low (code-1) bits of the prescaler set the period
  always_comb begin
    mask = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (rate_code != '0 && i < int'(rate_code) - 1) mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (restart)  cnt_q <= MID;
    else if (ref_tick) cnt_q <= cnt_q + 1'b1;
  end

  assign per_evt = ref_tick && !restart && (rate_code != '0) &&
                   ((cnt_q & mask) == mask);

  // R10: a time-set strobe parks the prescaler at its midpoint
  a_r10_restart_mid: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == MID));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_irq_pkg::*;
#(
  parameter int NF   = 5,
  parameter int NACT = 5
) (
  input  logic [NF*DATA_W-1:0] al_vec,
  input  logic [NF*DATA_W-1:0] cur_vec,
  output logic                 hit
);
  logic [NF-1:0] f_ok;

  for (genvar f = 0; f < NF; f++) begin : g_field
    if (f < NACT) begin : g_used
      assign f_ok[f] = field_hit(al_vec[f*DATA_W +: DATA_W],
                                 cur_vec[f*DATA_W +: DATA_W]);
    end else begin : g_unused
      assign f_ok[f] = 1'b1;
    end
  end

  assign hit = &f_ok;
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] en_next,
  input  logic            rd_clr,
  output logic [NSRC-1:0] flags_q,
  output logic            irq
);
  logic [NSRC-1:0] flags_d;

  // an event in the read cycle survives the clear
  assign flags_d = (rd_clr ? '0 : flags_q) | evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq     <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq     <= |(flags_d & en_next);
    end
  end

  // R5 and R8: every event leaves its flag set, read or no read
  a_r5_event_latches: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((flags_q & $past(evt)) == $past(evt)));

  // R7: a read with no event empties the flags
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !(|evt)) |=> (flags_q == '0));
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int DIV_W      = 15,
  parameter int CODE_W     = 4,
  parameter int RESET_CODE = 6,
  parameter bit EXT_ALARM  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              sec_tick,
  input  logic              time_wr,
  input  logic [DATA_W-1:0] cur_sec,
  input  logic [DATA_W-1:0] cur_min,
  input  logic [DATA_W-1:0] cur_hour,
  input  logic [DATA_W-1:0] cur_day,
  input  logic [DATA_W-1:0] cur_mon,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int NF   = 5;
  localparam int NACT = EXT_ALARM ? 5 : 3;
  localparam int PADW = DATA_W - CODE_W;
  localparam int ENPW = DATA_W - NSRC;

  logic [CODE_W-1:0] rate_q;
  logic [NSRC-1:0]   en_q, en_d;
  logic [DATA_W-1:0] al_sec_q, al_min_q, al_hour_q, al_day_q, al_mon_q;
  logic [NSRC-1:0]   src_evt, flg_q;
  logic              per_evt, al_hit, rd_clr, summary;

  // ---------------- register writes ----------------
  assign en_d = (reg_wr && reg_addr == A_CTRL) ? reg_wdata[NSRC-1:0] : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q    <= CODE_W'(RESET_CODE);
      en_q      <= '0;
      al_sec_q  <= '0;
      al_min_q  <= '0;
      al_hour_q <= '0;
      al_day_q  <= '0;
      al_mon_q  <= '0;
    end else begin
      en_q <= en_d;
      if (reg_wr) begin
        case (reg_addr)
          A_RATE:  rate_q    <= reg_wdata[CODE_W-1:0];
          A_ASEC:  al_sec_q  <= reg_wdata;
          A_AMIN:  al_min_q  <= reg_wdata;
          A_AHOUR: al_hour_q <= reg_wdata;
          A_ADAY:  al_day_q  <= reg_wdata;
          A_AMON:  al_mon_q  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // ---------------- event sources ----------------
  rtc_prescaler #(.DIV_W(DIV_W), .CODE_W(CODE_W)) u_presc (
    .clk       (clk),
    .rst       (rst),
    .ref_tick  (ref_tick),
    .restart   (time_wr),
    .rate_code (rate_q),
    .per_evt   (per_evt)
  );

  rtc_alarm_match #(.NF(NF), .NACT(NACT)) u_match (
    .al_vec  ({al_mon_q, al_day_q, al_hour_q, al_min_q, al_sec_q}),
    .cur_vec ({cur_mon, cur_day, cur_hour, cur_min, cur_sec}),
    .hit     (al_hit)
  );

  always_comb begin
    src_evt        = '0;
    src_evt[B_PER] = per_evt;
    src_evt[B_ALM] = sec_tick && al_hit;
    src_evt[B_UPD] = sec_tick;
  end

  assign rd_clr = reg_rd && (reg_addr == A_FLAG);

  rtc_irq_flags #(.NSRC(NSRC)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .evt     (src_evt),
    .en_next (en_d),
    .rd_clr  (rd_clr),
    .flags_q (flg_q),
    .irq     (irq)
  );

  assign summary = |(flg_q & en_q);

  // ---------------- register reads ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_RATE:  reg_rdata <= {{PADW{1'b0}}, rate_q};
        A_CTRL:  reg_rdata <= {{ENPW{1'b0}}, en_q};
        A_FLAG: begin
          reg_rdata                  <= '0;
          reg_rdata[NSRC-1:0]        <= flg_q;
          reg_rdata[B_SUM]           <= summary;
        end
        A_ASEC:  reg_rdata <= al_sec_q;
        A_AMIN:  reg_rdata <= al_min_q;
        A_AHOUR: reg_rdata <= al_hour_q;
        A_ADAY:  reg_rdata <= EXT_ALARM ? {2'b00, al_day_q[DATA_W-3:0]} : '0;
        A_AMON:  reg_rdata <= EXT_ALARM ? al_mon_q : '0;
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R6: the line is high only with an enabled pending flag behind it
  a_r6_irq_has_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> |(flg_q & en_q));

  // R4: every seconds tick leaves the update flag set
  a_r4_update_each_tick: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> flg_q[B_UPD]);

  // R11: a write to the flags address leaves them alone
  a_r11_flag_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_FLAG && !reg_rd && !(|src_evt)) |=> $stable(flg_q));
endmodule

// File: tb/rtc_irq_unit_test.sv
module rtc_irq_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_tick = 1'b0, sec_tick = 1'b0, time_wr = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_day = '0, cur_mon = '0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_irq_unit uut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .sec_tick(sec_tick),
    .time_wr(time_wr), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_day(cur_day), .cur_mon(cur_mon),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {alarm sec,min,hour,day,mon, time sec,min,hour,day,mon, expected hit}
  localparam int NV = 9;
  localparam logic [80:0] VEC [0:NV-1] = '{
    {8'h30,8'h15,8'h08,8'h12,8'h06, 8'h30,8'h15,8'h08,8'h12,8'h06, 1'b1},
    {8'h30,8'h15,8'h08,8'h12,8'h06, 8'h31,8'h15,8'h08,8'h12,8'h06, 1'b0},
    {8'hFF,8'hFF,8'hFF,8'hFF,8'hFF, 8'h47,8'h22,8'h19,8'h28,8'h02, 1'b1},
    {8'hC0,8'h15,8'h08,8'h12,8'h06, 8'h59,8'h15,8'h08,8'h12,8'h06, 1'b1},
    {8'h00,8'h00,8'h08,8'hFF,8'hFF, 8'h00,8'h00,8'h09,8'h01,8'h01, 1'b0},
    {8'h10,8'h20,8'h23,8'h12,8'h11, 8'h10,8'h20,8'h23,8'h13,8'h11, 1'b0},
    {8'h10,8'h20,8'h23,8'h31,8'hFF, 8'h10,8'h20,8'h23,8'h31,8'h07, 1'b1},
    {8'h05,8'hC3,8'h00,8'h01,8'h01, 8'h05,8'h42,8'h00,8'h01,8'h01, 1'b1},
    {8'h05,8'h80,8'h00,8'h01,8'h01, 8'h05,8'h00,8'h00,8'h01,8'h01, 1'b0}
  };

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse_sec();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic measure(input int code, output int per);
    logic [7:0] d;
    int t0;
    wr(3'd0, 8'(code));
    wr(3'd1, 8'h04);
    rd(3'd2, d);
    wait_irq();
    t0 = cyc;
    rd(3'd2, d);
    wait_irq();
    per = cyc - t0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int per, t0;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq after reset", irq, 0);
    rd(3'd0, d); chk("R1 rate code", d, 8'h06);
    rd(3'd1, d); chk("R1 control", d, 8'h00);
    rd(3'd2, d); chk("R1 flags", d, 8'h00);

    // R3 / R4 alarm vectors
    for (int i = 0; i < NV; i++) begin
      wr(3'd3, VEC[i][80:73]); wr(3'd4, VEC[i][72:65]);
      wr(3'd5, VEC[i][64:57]); wr(3'd6, VEC[i][56:49]);
      wr(3'd7, VEC[i][48:41]);
      cur_sec = VEC[i][40:33]; cur_min = VEC[i][32:25];
      cur_hour = VEC[i][24:17]; cur_day = VEC[i][16:9];
      cur_mon = VEC[i][8:1];
      rd(3'd2, d);
      pulse_sec();
      rd(3'd2, d);
      chk($sformatf("R3 alarm vector %0d", i), int'(d[1]), int'(VEC[i][0]));
      chk($sformatf("R4 update flag vector %0d", i), int'(d[0]), 1);
    end

    // R5 / R6: latched while disabled, no irq; enable raises irq and summary
    wr(3'd1, 8'h00);
    rd(3'd2, d);
    pulse_sec();
    chk("R6 irq low with flag but no enable", irq, 0);
    rd(3'd2, d); chk("R5 flag latched while disabled", d, 8'h01);
    pulse_sec();
    wr(3'd1, 8'h01);
    chk("R6 irq high after enable", irq, 1);
    rd(3'd1, d); chk("R5 control readback", d, 8'h01);
    // R11 write to flags ignored
    wr(3'd2, 8'h00);
    chk("R11 irq kept after flags write", irq, 1);
    rd(3'd2, d); chk("R6 R7 flags with summary", d, 8'h81);
    chk("R7 irq low after read", irq, 0);
    rd(3'd2, d); chk("R7 second read empty", d, 8'h00);
    wr(3'd2, 8'hFF);
    rd(3'd2, d); chk("R11 write did not set flags", d, 8'h00);

    // R8 event in the read cycle stays pending
    @(negedge clk);
    reg_addr = 3'd2; reg_rd = 1'b1; sec_tick = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; sec_tick = 1'b0;
    chk("R8 read returns pre-event flags", reg_rdata, 8'h00);
    chk("R8 irq from pending event", irq, 1);
    rd(3'd2, d); chk("R8 event kept", d, 8'h81);

    // R9 day alarm readback
    wr(3'd6, 8'hC5); rd(3'd6, d); chk("R9 day top bits dropped", d, 8'h05);
    wr(3'd6, 8'h25); rd(3'd6, d); chk("R9 day plain", d, 8'h25);
    wr(3'd7, 8'hFF); rd(3'd7, d); chk("R9 month full byte", d, 8'hFF);

    // R2 periodic rates
    wr(3'd1, 8'h00);
    ref_tick = 1'b1;
    measure(3, per);  chk("R2 period code 3", per, 4);
    measure(6, per);  chk("R2 period code 6", per, 32);
    measure(10, per); chk("R2 period code 10", per, 512);
    wr(3'd0, 8'h00);
    rd(3'd2, d);
    repeat (200) @(negedge clk);
    rd(3'd2, d); chk("R2 code 0 no periodic flag", int'(d[2]), 0);
    chk("R2 code 0 irq low", irq, 0);

    // R10 time-set strobe restarts the prescaler at its midpoint
    wr(3'd0, 8'h06);
    wr(3'd1, 8'h04);
    rd(3'd2, d);
    wait_irq();
    repeat (10) @(negedge clk);
    reg_addr = 3'd2; reg_rd = 1'b1; time_wr = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; time_wr = 1'b0;
    t0 = cyc;
    chk("R10 irq low after strobe", irq, 0);
    wait_irq();
    chk("R10 ticks to first event after strobe", cyc - t0, 32);
    ref_tick = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule